// File: doc/BRIEF.md
# Thermal Threshold Alarm Controller

This block watches a stream of temperature conversion results and decides when a thermal alarm line should be driven. Each result arrives as a signed 9-bit word in half-degree steps, qualified by a one-cycle valid strobe. The block keeps two thresholds, an upper trip point and a lower release point. Both are compared with the incoming sample as signed numbers. A small configuration register selects the behaviour of the alarm, its output polarity, a shutdown state and the depth of a consecutive-sample filter.

The alarm works in one of two modes. As a thermostat, it trips when the sample rises above the trip point and releases once the sample is at or below the release point. As a latched event flag, it trips on each qualified crossing and stays set until software performs any register read. After each event the direction being watched flips. The filter lets the alarm act only after a programmed run of consecutive samples that all satisfy the pending condition. The output models an open-drain pin: it either pulls the line low or lets it go.

Top module: `thermal_alarm_ctrl`

## Requirements
- R1: After reset, the alarm is inactive and the pull output is released. Reading back gives trip point 160 (80 degrees), release point 150, configuration 0 and temperature 0.
- R2: Register selects are 0 = temperature, 1 = configuration, 2 = release point and 3 = trip point. A read strobe returns the selected register on rd_data one cycle later. A write to select 0 has no effect.
- R3: While running, every valid conversion is stored as the temperature register. All comparisons treat samples and thresholds as 9-bit two's-complement values.
- R4: In thermostat mode (configuration bit 1 = 0), the alarm becomes active once the sample is strictly above the trip point. It becomes inactive once the sample is at or below the release point. Samples between the two leave it unchanged, and reads have no effect.
- R5: In latched mode (configuration bit 1 = 1), a qualified event sets the alarm. The alarm stays set whatever later samples show, until a read of any register clears it. If a qualifying event and a read fall in the same cycle, the event wins.
- R6: In latched mode, the watched condition alternates. It starts as "above the trip point". After each qualified event it becomes the other condition, "at or below the release point", and so on.
- R7: Configuration bits 4:3 give the filter depth: 0 means 1, 1 means 2, 2 means 4 and 3 means 6 consecutive samples. The alarm acts only on the last sample of such a run. A sample that fails the pending condition restarts the count.
- R8: With the shutdown bit (configuration bit 0) set, conversions are ignored and the temperature register holds its value. The trip and release registers stay writable and readable.
- R9: Setting the shutdown bit clears the alarm in latched mode and leaves it unchanged in thermostat mode.
- R10: A write that changes the mode bit or the shutdown bit restarts the filter count. A mode change also clears the alarm and makes "above the trip point" the watched condition.
- R11: With configuration bit 2 = 0 (active-low), alarm_pull is 1 while the alarm is active. With bit 2 = 1, alarm_pull is 1 while the alarm is inactive. alarm_pull follows alarm_active and the polarity bit one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_valid | input | 1 | New conversion result present this cycle |
| conv_temp | input | 9 | Signed conversion result, half-degree steps |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 9 | Write data |
| rd_en | input | 1 | Register read strobe (clears a latched alarm) |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 9 | Read data, valid the cycle after rd_en |
| alarm_active | output | 1 | Logical alarm state |
| alarm_pull | output | 1 | 1 = pull the open-drain line low, 0 = release |

## Verification
The alarm is driven with slow ramps that cross both thresholds upward and downward, and ramps that hover in the band between them. These show whether the trip point is strict, whether the release point is inclusive, and whether the band holds its state. Each ramp runs at every filter depth, interleaved with runs of samples that alternate between qualifying and not. This separates a true consecutive count from a cumulative one. In latched mode the same ramps are mixed with periodic reads of rotating selects, which shows that the latch is cleared by any read and that the watched condition alternates. Shutdown and mode writes are issued with the alarm both set and clear, and under both polarities.

// File: rtl/thermal_alarm_pkg.sv
package thermal_alarm_pkg;

  localparam int CFG_W = 5;

  typedef enum logic [1:0] {
    SEL_TEMP  = 2'd0,
    SEL_CFG   = 2'd1,
    SEL_HYST  = 2'd2,
    SEL_SETPT = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [1:0] depth_code;
    logic       act_high;
    logic       int_mode;
    logic       shutdown;
  } cfg_t;

endpackage

// File: rtl/ta_regfile.sv
module ta_regfile
  import thermal_alarm_pkg::*;
#(
  parameter int TEMP_W    = 9,
  parameter int SETPT_RST = 160,
  parameter int HYST_RST  = 150
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_valid,
  input  logic [TEMP_W-1:0] conv_temp,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [TEMP_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [1:0]        rd_sel,
  output logic [TEMP_W-1:0] rd_data,
  output cfg_t              cfg_q,
  output logic [TEMP_W-1:0] setpt_q,
  output logic [TEMP_W-1:0] hyst_q,
  output logic              sample,
  output logic              mode_chg,
  output logic              sd_chg,
  output logic              sd_enter
);

  localparam int PAD_W = TEMP_W - CFG_W;

  logic [TEMP_W-1:0] temp_q;
  logic              cfg_wr;
  cfg_t              cfg_new;

  assign cfg_wr   = wr_en && (reg_sel_e'(wr_sel) == SEL_CFG);
  assign cfg_new  = cfg_t'(wr_data[CFG_W-1:0]);
  assign mode_chg = cfg_wr && (cfg_new.int_mode != cfg_q.int_mode);
  assign sd_chg   = cfg_wr && (cfg_new.shutdown != cfg_q.shutdown);
  assign sd_enter = sd_chg && cfg_new.shutdown;
  assign sample   = conv_valid && !cfg_q.shutdown;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      setpt_q <= TEMP_W'(SETPT_RST);
      hyst_q  <= TEMP_W'(HYST_RST);
    end else if (wr_en) begin
      case (reg_sel_e'(wr_sel))
        SEL_CFG:   cfg_q   <= cfg_new;
        SEL_HYST:  hyst_q  <= wr_data;
        SEL_SETPT: setpt_q <= wr_data;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) temp_q <= '0;
    else if (sample) temp_q <= conv_temp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (reg_sel_e'(rd_sel))
        SEL_TEMP:  rd_data <= temp_q;
        SEL_CFG:   rd_data <= {{PAD_W{1'b0}}, cfg_q};
        SEL_HYST:  rd_data <= hyst_q;
        default:   rd_data <= setpt_q;
      endcase
    end
  end

  AST_SD_TEMP_HOLD: assert property (@(posedge clk) disable iff (rst)
    cfg_q.shutdown |=> $stable(temp_q)); // R8
  AST_CONV_STORED: assert property (@(posedge clk) disable iff (rst)
    (conv_valid && !cfg_q.shutdown) |=> (temp_q == $past(conv_temp))); // R3

endmodule

// File: rtl/ta_fault_queue.sv
module ta_fault_queue #(
  parameter int QUEUE_MAX = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       sample,
  input  logic       cond,
  input  logic [1:0] depth_code,
  output logic       qualify
);

  localparam int CNT_W = $clog2(QUEUE_MAX + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   need_n;
  logic [CNT_W:0]   cnt_inc;

  always_comb begin
    case (depth_code)
      2'd0:    need_n = (CNT_W+1)'(1);
      2'd1:    need_n = (CNT_W+1)'(2);
      2'd2:    need_n = (CNT_W+1)'(4);
      default: need_n = (CNT_W+1)'(QUEUE_MAX);
    endcase
  end

  assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign qualify = sample && cond && !clr && (cnt_inc >= need_n);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (sample) begin
      if (cond && !qualify) cnt_q <= cnt_inc[CNT_W-1:0];
      else                  cnt_q <= '0;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CNT_W'(QUEUE_MAX)); // R7
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0)); // R10
  AST_MISS_RESTART: assert property (@(posedge clk) disable iff (rst)
    (sample && !cond) |=> (cnt_q == '0)); // R7

endmodule

// File: rtl/ta_alarm_fsm.sv
module ta_alarm_fsm #(
  parameter int TEMP_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              int_mode,
  input  logic              mode_chg,
  input  logic              sd_chg,
  input  logic              sd_enter,
  input  logic              shutdown,
  input  logic              sample,
  input  logic              rd_en,
  input  logic [TEMP_W-1:0] temp_in,
  input  logic [TEMP_W-1:0] setpt,
  input  logic [TEMP_W-1:0] hyst,
  input  logic              qualify,
  output logic              cond,
  output logic              clr,
  output logic              alarm_q
);

  logic seek_high_q;
  logic above;
  logic below;
  logic cfg_chg;

  assign above   = $signed(temp_in) >  $signed(setpt);
  assign below   = $signed(temp_in) <= $signed(hyst);
  assign cfg_chg = mode_chg || sd_chg;
  assign clr     = cfg_chg;

  always_comb begin
    if (int_mode) cond = seek_high_q ? above : below;
    else          cond = alarm_q ? below : above;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_q     <= 1'b0;
      seek_high_q <= 1'b1;
    end else if (mode_chg) begin
      alarm_q     <= 1'b0;
      seek_high_q <= 1'b1;
    end else if (sd_enter && int_mode) begin
      alarm_q     <= 1'b0;
      seek_high_q <= 1'b1;
    end else if (qualify) begin
      if (int_mode) begin
        alarm_q     <= 1'b1;
        seek_high_q <= !seek_high_q;
      end else begin
        alarm_q <= !alarm_q;
      end
    end else if (rd_en && int_mode) begin
      alarm_q <= 1'b0;
    end
  end

  AST_INT_SD_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (sd_enter && int_mode) |=> !alarm_q); // R9
  AST_CMP_SD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (shutdown && !int_mode && !cfg_chg) |=> $stable(alarm_q)); // R9
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_en && int_mode && !qualify) |=> !alarm_q); // R5
  AST_MODE_REARM: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (!alarm_q && seek_high_q)); // R10
  AST_CMP_NO_TRIP: assert property (@(posedge clk) disable iff (rst)
    (!int_mode && !cfg_chg && sample && !alarm_q && !above) |=> !alarm_q); // R4
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (int_mode && alarm_q && !rd_en && !cfg_chg) |=> alarm_q); // R5

endmodule

// File: rtl/ta_out_stage.sv
module ta_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic act_high,
  output logic pull_q
);

  always_ff @(posedge clk) begin
    if (rst) pull_q <= 1'b0;
    else     pull_q <= active ^ act_high;
  end

  AST_PULL_POLARITY: assert property (@(posedge clk) disable iff (rst)
    pull_q == ($past(active) ^ $past(act_high))); // R11

endmodule

// File: rtl/thermal_alarm_ctrl.sv
module thermal_alarm_ctrl
  import thermal_alarm_pkg::*;
#(
  parameter int TEMP_W    = 9,
  parameter int QUEUE_MAX = 6,
  parameter int SETPT_RST = 160,
  parameter int HYST_RST  = 150
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_valid,
  input  logic [TEMP_W-1:0] conv_temp,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [TEMP_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [1:0]        rd_sel,
  output logic [TEMP_W-1:0] rd_data,
  output logic              alarm_active,
  output logic              alarm_pull
);

  cfg_t              cfg_q;
  logic [TEMP_W-1:0] setpt_q;
  logic [TEMP_W-1:0] hyst_q;
  logic              sample;
  logic              mode_chg;
  logic              sd_chg;
  logic              sd_enter;
  logic              cond;
  logic              clr;
  logic              qualify;

  ta_regfile #(
    .TEMP_W   (TEMP_W),
    .SETPT_RST(SETPT_RST),
    .HYST_RST (HYST_RST)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .conv_valid(conv_valid),
    .conv_temp (conv_temp),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_sel    (rd_sel),
    .rd_data   (rd_data),
    .cfg_q     (cfg_q),
    .setpt_q   (setpt_q),
    .hyst_q    (hyst_q),
    .sample    (sample),
    .mode_chg  (mode_chg),
    .sd_chg    (sd_chg),
    .sd_enter  (sd_enter)
  );

  ta_fault_queue #(
    .QUEUE_MAX(QUEUE_MAX)
  ) u_queue (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .sample    (sample),
    .cond      (cond),
    .depth_code(cfg_q.depth_code),
    .qualify   (qualify)
  );

  ta_alarm_fsm #(
    .TEMP_W(TEMP_W)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .int_mode(cfg_q.int_mode),
    .mode_chg(mode_chg),
    .sd_chg  (sd_chg),
    .sd_enter(sd_enter),
    .shutdown(cfg_q.shutdown),
    .sample  (sample),
    .rd_en   (rd_en),
    .temp_in (conv_temp),
    .setpt   (setpt_q),
    .hyst    (hyst_q),
    .qualify (qualify),
    .cond    (cond),
    .clr     (clr),
    .alarm_q (alarm_active)
  );

  ta_out_stage u_out (
    .clk     (clk),
    .rst     (rst),
    .active  (alarm_active),
    .act_high(cfg_q.act_high),
    .pull_q  (alarm_pull)
  );

endmodule

// File: tb/thermal_alarm_ctrl_bench.sv
module thermal_alarm_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       conv_valid = 1'b0;
  logic [8:0] conv_temp = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [8:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [1:0] rd_sel = '0;
  logic [8:0] rd_data;
  logic       alarm_active;
  logic       alarm_pull;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state, derived from the requirements
  int m_set, m_hyst, m_temp, m_cnt;
  bit m_alarm, m_seek, m_sd, m_int, m_pol;
  int m_dcode;

  always #4 clk = ~clk;

  thermal_alarm_ctrl u_thermal_alarm_ctrl (
    .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_temp(conv_temp),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .alarm_active(alarm_active), .alarm_pull(alarm_pull)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int sx(input int v);
    logic [8:0] b;
    b = 9'(v);
    return int'($signed(b));
  endfunction

  function automatic int depth_of(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return 6;
    endcase
  endfunction

  function automatic int cfg_word();
    return (m_dcode << 3) | (int'(m_pol) << 2) | (int'(m_int) << 1) | int'(m_sd);
  endfunction

  task automatic write_reg(input int sel, input int data);
    wr_en = 1; wr_sel = 2'(sel); wr_data = 9'(data);
    tick();
    wr_en = 0;
    if (sel == 1) begin
      bit n_sd, n_int;
      n_sd = data[0]; n_int = data[1];
      if (n_int != m_int) begin m_alarm = 0; m_seek = 1; m_cnt = 0; end
      else if (n_sd != m_sd) begin
        m_cnt = 0;
        if (n_sd && m_int) begin m_alarm = 0; m_seek = 1; end
      end
      m_sd = n_sd; m_int = n_int; m_pol = data[2]; m_dcode = (data >> 3) & 3;
    end else if (sel == 2) m_hyst = sx(data);
    else if (sel == 3) m_set = sx(data);
  endtask

  task automatic read_reg(input int sel, input string req);
    int exp;
    case (sel)
      0: exp = m_temp & 9'h1ff;
      1: exp = cfg_word();
      2: exp = m_hyst & 9'h1ff;
      default: exp = m_set & 9'h1ff;
    endcase
    rd_en = 1; rd_sel = 2'(sel);
    tick();
    rd_en = 0;
    chk(req, int'(rd_data), exp);
    if (m_int) m_alarm = 0;
  endtask

  task automatic convert(input int t, input string req);
    bit c;
    conv_valid = 1; conv_temp = 9'(t);
    tick();
    conv_valid = 0;
    if (!m_sd) begin
      m_temp = t;
      if (m_int) c = m_seek ? (t > m_set) : (t <= m_hyst);
      else       c = m_alarm ? (t <= m_hyst) : (t > m_set);
      if (c) begin
        m_cnt++;
        if (m_cnt >= depth_of(m_dcode)) begin
          m_cnt = 0;
          if (m_int) begin m_alarm = 1; m_seek = !m_seek; end
          else m_alarm = !m_alarm;
        end
      end else m_cnt = 0;
    end
    chk(req, int'(alarm_active), int'(m_alarm));
  endtask

  task automatic ramps(input string req, input bit with_reads);
    int k = 0;
    for (int t = -40; t <= 70; t += 3) begin
      convert(t, req);
      if (with_reads && (k % 7) == 6) read_reg(k % 4, "R5");
      k++;
    end
    for (int t = 70; t >= -40; t -= 4) begin
      convert(t, req);
      if (with_reads && (k % 5) == 4) read_reg(k % 4, "R5");
      k++;
    end
    // hover inside the band, then alternate qualifying and non-qualifying
    for (int i = 0; i < 8; i++) convert(25 + (i % 3), req);
    for (int i = 0; i < 12; i++) convert((i % 3 == 2) ? 30 : 60, req);
    for (int i = 0; i < 8; i++) convert(60, req);
    for (int i = 0; i < 12; i++) convert((i % 3 == 2) ? 30 : 10, req);
    for (int i = 0; i < 8; i++) convert(10, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    m_set = 160; m_hyst = 150; m_temp = 0; m_cnt = 0;
    m_alarm = 0; m_seek = 1; m_sd = 0; m_int = 0; m_pol = 0; m_dcode = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    tick();
    // R1 reset state
    chk("R1 active", int'(alarm_active), 0);
    chk("R1 pull", int'(alarm_pull), 0);
    for (int s = 0; s < 4; s++) read_reg(s, "R1");

    // R2 register access, write to temperature ignored
    write_reg(0, 9'h055);
    read_reg(0, "R2");
    for (int v = -256; v < 256; v += 37) begin
      write_reg(2, v); write_reg(3, v + 11);
      read_reg(2, "R2"); read_reg(3, "R2");
    end

    // R3 capture of signed samples
    write_reg(3, 200); write_reg(2, 190);
    for (int t = -256; t < 256; t += 29) begin
      convert(t, "R3"); read_reg(0, "R3");
    end

    // thermostat mode, all depths, negative thresholds too
    for (int d = 0; d < 4; d++) begin
      write_reg(3, 40); write_reg(2, 20);
      write_reg(1, d << 3);
      ramps("R4,R7", 0);
      read_reg(1, "R4");
      chk("R4 read no effect", int'(alarm_active), int'(m_alarm));
      write_reg(3, -10); write_reg(2, -30);
      ramps("R4,R3", 0);
    end

    // latched mode with interleaved reads, all depths
    for (int d = 0; d < 4; d++) begin
      write_reg(3, 40); write_reg(2, 20);
      write_reg(1, (d << 3) | 2);
      ramps("R5,R6,R7", 1);
      write_reg(1, d << 3);
      chk("R10 mode change clears", int'(alarm_active), 0);
    end

    // R6 alternate direction after clear
    write_reg(1, 2);
    convert(60, "R6"); read_reg(0, "R5");
    convert(60, "R6 no retrip while seeking low");
    convert(10, "R6 low event");
    read_reg(2, "R5");
    convert(10, "R6 rearmed for high");
    convert(60, "R6 high event");
    // event and read in same cycle: event wins
    convert(10, "R6");
    read_reg(3, "R5");
    conv_valid = 1; conv_temp = 9'(60); rd_en = 1; rd_sel = 0;
    tick();
    conv_valid = 0; rd_en = 0;
    m_temp = 60; m_alarm = 1; m_seek = 0;
    chk("R5 event beats read", int'(alarm_active), 1);

    // R8/R9 shutdown, thermostat holds
    write_reg(1, 0);
    convert(60, "R4");
    write_reg(1, 1);
    chk("R9 thermostat hold", int'(alarm_active), 1);
    convert(-50, "R8 ignored");
    read_reg(0, "R8 temp held");
    write_reg(3, 77); write_reg(2, -77);
    read_reg(3, "R8"); read_reg(2, "R8");
    write_reg(3, 40); write_reg(2, 20);
    write_reg(1, 0);
    convert(10, "R8 resumed");

    // R9 latched cleared on shutdown entry
    write_reg(1, 2);
    convert(60, "R5");
    chk("R5 set", int'(alarm_active), 1);
    write_reg(1, 3);
    chk("R9 latched cleared", int'(alarm_active), 0);
    convert(60, "R8 ignored");
    write_reg(1, 2);
    convert(60, "R9 rearmed high");

    // R10 count restart on shutdown toggle (depth 4)
    write_reg(1, (2 << 3));
    for (int i = 0; i < 3; i++) convert(60, "R7");
    write_reg(1, (2 << 3) | 1); write_reg(1, (2 << 3));
    for (int i = 0; i < 3; i++) convert(60, "R10 restart");
    convert(60, "R10 fourth");

    // R11 polarity
    for (int p = 0; p < 2; p++) begin
      write_reg(1, p << 2);
      convert(10, "R4");
      tick();
      chk("R11 inactive", int'(alarm_pull), int'(m_alarm) ^ p);
      convert(60, "R4");
      tick();
      chk("R11 active", int'(alarm_pull), int'(m_alarm) ^ p);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule